// File: doc/BRIEF.md
# Address-Masked GPIO Port Controller

This block is an eight-pin general-purpose I/O port that sits on a simple single-cycle register bus. The bus carries an address, a write strobe, write data and read data. Writes take effect at the rising clock edge when the strobe is high. Read data is a combinational function of the address. The pin data register covers a whole window of offsets, and address bits [9:2] of an access act as a per-pin mask. Software can therefore set, clear or sample any subset of pins with one store or load, and no read-modify-write sequence is needed.

Each pin has a direction bit and a digital-enable bit, and the pin drives only when both are set. A key-protected lock and a commit register guard the configuration of chosen pins. Out of reset, pin 0 is the only guarded pin. Changing it takes three steps: write the key to the lock register, set commit bit 0, then write the direction or digital-enable register. Input levels pass through a two-flop synchroniser before any read can see them.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, `pin_out` and `pin_oe` are 0, the direction and digital-enable registers read 0, the commit register reads 0xFE, and the lock register reads 1.
- R2: A write to any offset in 0x000..0x3FC uses address bits [9:2] as a mask. Only the data bits whose mask bit is 1 take the written value (offset 0x008 touches pin 1 only, offset 0x3FC touches all pins). The data bits appear on `pin_out` after the write edge.
- R3: A read in 0x000..0x3FC returns, for each masked bit, the data-register bit when the pin's direction bit is 1, and the synchronised input level when it is 0. Bits outside the mask and bits 31:8 read as 0.
- R4: The direction register sits at offset 0x400 and reads back at the same offset. A 1 selects output and a 0 selects input.
- R5: The digital-enable register sits at offset 0x51C. `pin_oe` bit n is 1 exactly when both direction bit n and digital-enable bit n are 1.
- R6: A change on `pin_in` is invisible to a data read after one rising edge and visible after the second rising edge.
- R7: An input pin whose digital-enable bit is 0 reads as 0 through the data register, whatever level `pin_in` has.
- R8: A write of 0x4C4F434B to offset 0x520 unlocks the port, and the lock register then reads 0. A write of any other value locks it again, and it reads 1.
- R9: While the port is locked, writes to the commit register at offset 0x524 leave it unchanged. While it is unlocked, they load it.
- R10: Writes to the direction and digital-enable registers leave unchanged every bit whose commit bit is 0, and update every bit whose commit bit is 1. Out of reset this protects pin 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Output data per pin |
| pin_oe | output | 8 | Output enable per pin |

## Verification
Register writes become visible in read data and on `pin_out`/`pin_oe` right after the single edge that takes the write. Because of this, the bench reads back half a cycle after that edge, at the next falling edge. Input levels take two rising edges to reach read data. The bench applies each pin change at a falling edge and samples after the first and after the second following edge, so it checks both the hidden cycle and the visible one. All 256 masks are swept for both masked writes and masked reads, with every expected value computed from a bench model of the latch, direction and enable bits.

// File: rtl/gpio_mask_pkg.sv
// Package: shared offsets, unlock key and register-select type for the
// address-masked GPIO port. Assumes a 12-bit byte-offset bus, 32-bit data.
package gpio_mask_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_DIR    = 12'h400;
    localparam logic [ADDR_W-1:0] OFS_DEN    = 12'h51C;
    localparam logic [ADDR_W-1:0] OFS_LOCK   = 12'h520;
    localparam logic [ADDR_W-1:0] OFS_COMMIT = 12'h524;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h4C4F434B;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_DIR,
        SEL_DEN,
        SEL_LOCK,
        SEL_COMMIT
    } reg_sel_e;

    // Map an offset to a register; the data window spans offsets whose bits
    // above the mask field are all zero.
    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a,
                                            input int unsigned pins);
        reg_sel_e s;
        s = SEL_NONE;
        if ((a >> (pins + 2)) == '0)  s = SEL_DATA;
        else if (a == OFS_DIR)        s = SEL_DIR;
        else if (a == OFS_DEN)        s = SEL_DEN;
        else if (a == OFS_LOCK)       s = SEL_LOCK;
        else if (a == OFS_COMMIT)     s = SEL_COMMIT;
        return s;
    endfunction
endpackage

// File: rtl/gpio_in_sync.sv
// Module: per-pin multi-stage synchroniser for asynchronous pin levels.
// Assumes STAGES >= 2 and small; all stages clear on synchronous reset.
module gpio_in_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] sync_out
);
    localparam int CNT_W = $clog2(STAGES + 1);

    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw pins into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= raw_in;
                end
            end else begin : g_next
                // Shift the level one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

    // Count edges since reset so the latency check starts once history exists.
    logic [CNT_W-1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                          warm_q <= '0;
        else if (warm_q != CNT_W'(STAGES))   warm_q <= warm_q + 1'b1;
    end

    // R6
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == CNT_W'(STAGES)) |-> (sync_out == $past(raw_in, STAGES)))
        else $error("synchroniser latency mismatch");
endmodule

// File: rtl/gpio_lock_ctl.sv
// Module: key lock and commit register. The port starts locked; the key
// unlocks it, any other lock write relocks it. Commit writes need the unlock.
module gpio_lock_ctl
    import gpio_mask_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_wr,
    input  logic              commit_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              locked,
    output logic [W-1:0]      commit
);
    localparam logic [W-1:0] COMMIT_RST = {{(W-1){1'b1}}, 1'b0};

    // Track lock state from lock-register writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       locked <= 1'b1;
        else if (lock_wr) locked <= (wdata != UNLOCK_KEY);
    end

    // Load the commit mask only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)                    commit <= COMMIT_RST;
        else if (commit_wr && !locked) commit <= wdata[W-1:0];
    end

    // R8
    unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr && wdata == UNLOCK_KEY) |=> !locked)
        else $error("key did not unlock");

    // R8
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr && wdata != UNLOCK_KEY) |=> locked)
        else $error("non-key write did not relock");

    // R9
    commit_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_wr && locked) |=> $stable(commit))
        else $error("commit changed while locked");
endmodule

// File: rtl/gpio_cfg_reg.sv
// Module: one per-pin configuration register (direction or digital enable).
// Bits whose commit bit is 0 keep their value on writes.
module gpio_cfg_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] commit,
    output logic [W-1:0] q
);
    // Merge the write into committed bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= (q & ~commit) | (wr_data & commit);
    end

    // R10
    protect_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((q ^ $past(q)) & ~$past(commit)) == '0))
        else $error("protected configuration bit changed");

    // R10
    commit_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((q & $past(commit)) == ($past(wr_data) & $past(commit))))
        else $error("committed bit not written");

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q))
        else $error("configuration changed without a write");
endmodule

// File: rtl/gpio_mask_port.sv
// Module: top of the address-masked GPIO port. Decodes the register bus,
// holds the data latch, forms pin drive and enable, and muxes read data.
// Assumes a single-cycle bus: writes at the clock edge, reads combinational.
module gpio_mask_port
    import gpio_mask_pkg::*;
#(
    parameter int PIN_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe
);
    localparam int MASK_LO = 2;
    localparam int MASK_HI = MASK_LO + PIN_W - 1;

    reg_sel_e         sel;
    logic [PIN_W-1:0] acc_mask;
    logic [PIN_W-1:0] data_q;
    logic [PIN_W-1:0] dir_q;
    logic [PIN_W-1:0] den_q;
    logic [PIN_W-1:0] commit;
    logic [PIN_W-1:0] pin_sync;
    logic [PIN_W-1:0] pin_view;
    logic             locked;

    // Decode the access and pull the pin mask out of the address.
    always_comb begin
        sel      = decode_ofs(bus_addr, PIN_W);
        acc_mask = bus_addr[MASK_HI:MASK_LO];
    end

    gpio_lock_ctl #(.W(PIN_W)) i_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_wr   (bus_we && sel == SEL_LOCK),
        .commit_wr (bus_we && sel == SEL_COMMIT),
        .wdata     (bus_wdata),
        .locked    (locked),
        .commit    (commit)
    );

    gpio_cfg_reg #(.W(PIN_W)) i_dir (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we && sel == SEL_DIR),
        .wr_data (bus_wdata[PIN_W-1:0]),
        .commit  (commit),
        .q       (dir_q)
    );

    gpio_cfg_reg #(.W(PIN_W)) i_den (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we && sel == SEL_DEN),
        .wr_data (bus_wdata[PIN_W-1:0]),
        .commit  (commit),
        .q       (den_q)
    );

    gpio_in_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pin_in),
        .sync_out (pin_sync)
    );

    // Update only the masked bits of the data latch on a data write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (bus_we && sel == SEL_DATA)
            data_q <= (data_q & ~acc_mask) | (bus_wdata[PIN_W-1:0] & acc_mask);
    end

    // Drive pins from the latch; enable only digital outputs.
    always_comb begin
        pin_out = data_q;
        pin_oe  = dir_q & den_q;
    end

    // Per-pin read view: latch for outputs, gated synchronised level for inputs.
    always_comb begin
        pin_view = (dir_q & data_q) | (~dir_q & pin_sync & den_q);
    end

    // Select read data by register.
    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_DATA:   bus_rdata[PIN_W-1:0] = pin_view & acc_mask;
            SEL_DIR:    bus_rdata[PIN_W-1:0] = dir_q;
            SEL_DEN:    bus_rdata[PIN_W-1:0] = den_q;
            SEL_LOCK:   bus_rdata[0]         = locked;
            SEL_COMMIT: bus_rdata[PIN_W-1:0] = commit;
            default:    bus_rdata            = '0;
        endcase
    end

    // R2
    masked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == SEL_DATA) |=>
            (((pin_out ^ $past(pin_out)) & ~$past(acc_mask)) == '0))
        else $error("unmasked output bit changed");

    // R2
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && sel == SEL_DATA) |=> $stable(pin_out))
        else $error("output changed without a data write");

    // R3
    unmasked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_DATA) |-> ((bus_rdata[PIN_W-1:0] & ~acc_mask) == '0))
        else $error("unmasked bit returned data");
endmodule

// File: tb/test_gpio_mask_port.sv
module test_gpio_mask_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [7:0] m_lat, m_dir, m_den, m_com;
    logic [31:0] rd;

    always #5 clk = ~clk;

    gpio_mask_port i_gpio_mask_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rdreg(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [7:0] merge(input logic [7:0] o, input logic [7:0] n,
                                         input logic [7:0] m);
        return (o & ~m) | (n & m);
    endfunction

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        #1;
        chk("R1 pin_out", {24'h0, pin_out}, 32'h0);
        chk("R1 pin_oe",  {24'h0, pin_oe},  32'h0);
        rdreg(12'h400, rd); chk("R1 dir", rd, 32'h0);
        rdreg(12'h51C, rd); chk("R1 den", rd, 32'h0);
        rdreg(12'h524, rd); chk("R1 commit", rd, 32'hFE);
        rdreg(12'h520, rd); chk("R1 lock", rd, 32'h1);
        m_lat = 0; m_dir = 0; m_den = 0; m_com = 8'hFE;

        // R10 pin 0 protected out of reset; R4 direction readback
        wr(12'h400, 32'hFF); m_dir = merge(m_dir, 8'hFF, m_com);
        rdreg(12'h400, rd); chk("R10 dir pin0 protected", rd, 32'hFE);
        wr(12'h51C, 32'hFF); m_den = merge(m_den, 8'hFF, m_com);
        rdreg(12'h51C, rd); chk("R10 den pin0 protected", rd, 32'hFE);
        chk("R5 oe", {24'h0, pin_oe}, {24'h0, m_dir & m_den});
        wr(12'h400, 32'h0F); m_dir = merge(m_dir, 8'h0F, m_com);
        rdreg(12'h400, rd); chk("R4 dir write", rd, {24'h0, m_dir});
        chk("R5 oe after dir", {24'h0, pin_oe}, {24'h0, m_dir & m_den});

        // R9 commit ignored while locked
        wr(12'h524, 32'hFF);
        rdreg(12'h524, rd); chk("R9 locked commit", rd, 32'hFE);

        // R8 unlock, R9 commit loads
        wr(12'h520, 32'h4C4F434B);
        rdreg(12'h520, rd); chk("R8 unlocked", rd, 32'h0);
        wr(12'h524, 32'h0F); m_com = 8'h0F;
        rdreg(12'h524, rd); chk("R9 unlocked commit", rd, 32'h0F);
        wr(12'h520, 32'h4C4F434A);
        rdreg(12'h520, rd); chk("R8 relocked", rd, 32'h1);
        wr(12'h524, 32'h00);
        rdreg(12'h524, rd); chk("R9 commit after relock", rd, 32'h0F);

        // R10 commit 0x0F: upper nibble frozen, pin 0 now changeable
        wr(12'h400, 32'hF0); m_dir = merge(m_dir, 8'hF0, m_com);
        rdreg(12'h400, rd); chk("R10 dir under commit 0F", rd, {24'h0, m_dir});
        wr(12'h51C, 32'h01); m_den = merge(m_den, 8'h01, m_com);
        rdreg(12'h51C, rd); chk("R10 den under commit 0F", rd, {24'h0, m_den});

        // Open everything, then set dir 0x0F, den 0x3F
        wr(12'h520, 32'h4C4F434B);
        wr(12'h524, 32'hFF); m_com = 8'hFF;
        wr(12'h400, 32'h0F); m_dir = 8'h0F;
        wr(12'h51C, 32'h3F); m_den = 8'h3F;
        chk("R5 oe 0F/3F", {24'h0, pin_oe}, 32'h0F);

        // R2 sweep all masks
        for (int m = 0; m < 256; m++) begin
            logic [7:0] v;
            v = 8'((m * 37 + 11) & 8'hFF);
            wr(12'(m << 2), {24'hABCDEF, v});
            m_lat = merge(m_lat, v, 8'(m));
            #1 chk("R2 masked write", {24'h0, pin_out}, {24'h0, m_lat});
        end

        // R3/R7 read sweep with inputs settled
        pin_in = 8'hA5;
        repeat (3) @(posedge clk);
        for (int m = 0; m < 256; m++) begin
            rdreg(12'(m << 2), rd);
            chk("R3 R7 masked read", rd,
                {24'h0, ((m_dir & m_lat) | (~m_dir & pin_in & m_den)) & 8'(m)});
        end

        // R6 two-edge latency
        @(negedge clk) pin_in = 8'h5A;
        @(posedge clk);
        rdreg(12'h3FC, rd);
        chk("R6 hidden after one edge", rd,
            {24'h0, (m_dir & m_lat) | (~m_dir & 8'hA5 & m_den)});
        @(posedge clk);
        rdreg(12'h3FC, rd);
        chk("R6 visible after two edges", rd,
            {24'h0, (m_dir & m_lat) | (~m_dir & 8'h5A & m_den)});

        // R7 inputs with enable cleared read zero
        wr(12'h51C, 32'h00); m_den = 0;
        rdreg(12'h3FC, rd);
        chk("R7 den off", rd, {24'h0, m_dir & m_lat});
        chk("R5 oe den off", {24'h0, pin_oe}, 32'h0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule